// File: doc/BRIEF.md
# In-Order Retirement Buffer with Precise Faults

This block keeps the program order of instructions that a core issues out of order. Each instruction takes a slot at dispatch and receives a tag. The tag is the slot index with one extra wrap bit above it. Execution units report completion against that tag. A completion can carry a fault flag with a 4-bit cause code, or a mispredict flag for a branch. The oldest slot leaves the buffer only once it is complete. So results commit strictly in the order they were dispatched, whatever order they finish in.

A fault does not redirect anything when it is reported. It only marks the slot. The fault is acted on only if that slot becomes the oldest and is handed out on the retire stream. The retire beat then carries the exception flag, the cause and the PC. In that same cycle the block empties itself, and the flush output tells the rest of the core to discard everything. A mispredicted branch is handled differently: every slot younger than the branch is released in the cycle the report arrives. A fault sitting in one of those slots is lost with it. The branch itself retires later as a normal instruction.

Dispatch and retire are valid/ready streams. Dispatch is accepted when `disp_valid` and `disp_ready` are both high at a rising edge. `disp_ready` is low when every slot is taken and during any flush cycle. The retire beat is consumed when `ret_valid` and `ret_ready` are both high. While `ret_ready` is low, the beat and its fields stay unchanged. Completion reports are never back-pressured. `disp_ready` depends combinationally on `wb_valid`, `wb_mispredict` and `ret_ready`. Reset is asynchronous and active low.

Top module: `rob_precise`

## Requirements
- R1: Each accepted dispatch receives tag `disp_tag`, equal to the previous dispatch tag plus one modulo 2*DEPTH (tag bit IDX_W is the wrap bit, the low bits are the slot). The first tag after reset is 0.
- R2: `disp_ready` is low while DEPTH instructions are held and not yet retired. It is also low in any cycle where `flush_valid` is high.
- R3: Retire beats come out in dispatch order whatever order completions arrive in, at most one per cycle. A beat appears only once its instruction has completed. While `ret_ready` is low, `ret_valid`, `ret_tag` and `ret_pc` hold.
- R4: A completion with `wb_fault` high raises nothing immediately (`flush_valid` stays low). When that instruction is the oldest, its retire beat has `ret_exc` high, `ret_cause` equal to the reported cause and `ret_pc` equal to its dispatch PC.
- R5: In the cycle a beat with `ret_exc` high is consumed, `flush_valid` and `flush_all` are high. All held instructions are discarded, none of them retires, and the next dispatch tag is 0.
- R6: A completion with `wb_mispredict` high for a held instruction sets `flush_valid` high, `flush_all` low and `flush_tag` to that tag in the same cycle. All younger instructions are discarded, and the next dispatch tag is the branch tag plus one.
- R7: A fault on an instruction discarded by a mispredict never raises an exception. Completions whose tag names no held instruction change nothing and raise no flush.
- R8: After reset: `disp_ready` high, `ret_valid` low, `flush_valid` low, `disp_tag` 0.
- R9: A mispredicted branch that did not fault retires as a normal beat with `ret_exc` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | Slot free and no flush this cycle |
| disp_pc | input | PC_W | PC of the dispatched instruction |
| disp_tag | output | IDX_W+1 | Tag the next dispatch receives |
| wb_valid | input | 1 | Completion report |
| wb_tag | input | IDX_W+1 | Tag of the completed instruction |
| wb_fault | input | 1 | Instruction faulted |
| wb_cause | input | CAUSE_W | Fault cause code |
| wb_mispredict | input | 1 | Branch resolved against its prediction |
| ret_valid | output | 1 | Oldest instruction is complete |
| ret_ready | input | 1 | Consumer takes the retire beat |
| ret_tag | output | IDX_W+1 | Tag of the retiring instruction |
| ret_pc | output | PC_W | PC of the retiring instruction |
| ret_exc | output | 1 | Retiring instruction faulted |
| ret_cause | output | CAUSE_W | Cause of the fault |
| flush_valid | output | 1 | Discard event this cycle |
| flush_all | output | 1 | Discard is a full exception flush |
| flush_tag | output | IDX_W+1 | Branch tag (mispredict) or faulting tag (exception) |

## Verification
Most faults inside this block show up at the ports quickly. A wrong head pointer or a lost valid bit shows as a retire tag out of sequence. A stale done bit shows as a beat that appears before its completion. Either is visible on the first retire after the fault. A wrong tail after a mispredict shows on the very next dispatch tag. A slot left alive past a flush appears later, as a retire the scoreboard no longer expects. A fault bit that survives a squash, or reaches the wrong slot, appears as a wrong `ret_exc` on that slot's beat. The bench stresses these with completions in reverse and shuffled order, faults on either side of a mispredicted branch, a full buffer under back-pressure, and enough traffic to wrap the tags several times.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int unsigned ROB_DEPTH_DEF   = 8;
  localparam int unsigned ROB_CAUSE_W_DEF = 4;
  localparam int unsigned ROB_PC_W_DEF    = 32;

  // Pointer update requested by the top for this cycle.
  typedef enum logic [1:0] {
    PTR_HOLD       = 2'd0,
    PTR_BRANCH_CUT = 2'd1,
    PTR_CLEAR_ALL  = 2'd2
  } ptr_cmd_e;
endpackage

// File: rtl/rob_ptr_ctl.sv
module rob_ptr_ctl
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = ROB_DEPTH_DEF,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned TAG_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  ptr_cmd_e         cmd,
  input  logic [TAG_W-1:0] cut_tag,
  output logic [TAG_W-1:0] head_tag,
  output logic [TAG_W-1:0] tail_tag,
  output logic             full,
  output logic             empty
);
  localparam logic [TAG_W-1:0] ONE = TAG_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_tag <= '0;
      tail_tag <= '0;
    end else if (cmd == PTR_CLEAR_ALL) begin
      head_tag <= '0;
      tail_tag <= '0;
    end else begin
      if (retire_fire) head_tag <= head_tag + ONE;
      if (cmd == PTR_BRANCH_CUT) tail_tag <= cut_tag + ONE;
      else if (alloc_fire)       tail_tag <= tail_tag + ONE;
    end
  end

  assign empty = (head_tag == tail_tag);
  assign full  = (head_tag[IDX_W-1:0] == tail_tag[IDX_W-1:0]) &&
                 (head_tag[IDX_W] != tail_tag[IDX_W]);
endmodule

// File: rtl/rob_squash_mask.sv
module rob_squash_mask
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH = ROB_DEPTH_DEF,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0] head_idx,
  input  logic [IDX_W-1:0] br_idx,
  input  logic             cut_en,
  input  logic             clear_all,
  output logic [DEPTH-1:0] kill
);
  // Age of a slot is its distance from the head, modulo DEPTH.
  logic [IDX_W-1:0] br_age;
  assign br_age = br_idx - head_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    logic [IDX_W-1:0] slot_age;
    assign slot_age = IDX_W'(g) - head_idx;
    assign kill[g]  = clear_all | (cut_en & (slot_age > br_age));
  end
endmodule

// File: rtl/rob_entry_bank.sv
module rob_entry_bank
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH   = ROB_DEPTH_DEF,
  parameter int unsigned CAUSE_W = ROB_CAUSE_W_DEF,
  parameter int unsigned PC_W    = ROB_PC_W_DEF,
  localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_en,
  input  logic [IDX_W-1:0]   alloc_idx,
  input  logic               alloc_wrap,
  input  logic [PC_W-1:0]    alloc_pc,
  input  logic               wb_en,
  input  logic [IDX_W-1:0]   wb_idx,
  input  logic               wb_fault,
  input  logic [CAUSE_W-1:0] wb_cause,
  input  logic               retire_en,
  input  logic [IDX_W-1:0]   retire_idx,
  input  logic [DEPTH-1:0]   kill,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [DEPTH-1:0]   valid_o,
  output logic [DEPTH-1:0]   wrap_o,
  output logic               rd_done,
  output logic               rd_fault,
  output logic [CAUSE_W-1:0] rd_cause,
  output logic [PC_W-1:0]    rd_pc
);
  logic [DEPTH-1:0]   done_v;
  logic [DEPTH-1:0]   fault_v;
  logic [CAUSE_W-1:0] cause_a [DEPTH];
  logic [PC_W-1:0]    pc_a    [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic               v_q, w_q, d_q, f_q;
    logic [CAUSE_W-1:0] c_q;
    logic [PC_W-1:0]    p_q;
    logic               hit_alloc, hit_wb, hit_ret;

    assign hit_alloc = alloc_en  && (alloc_idx  == IDX_W'(g));
    assign hit_wb    = wb_en     && (wb_idx     == IDX_W'(g));
    assign hit_ret   = retire_en && (retire_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        w_q <= 1'b0;
        d_q <= 1'b0;
        f_q <= 1'b0;
        c_q <= '0;
        p_q <= '0;
      end else if (kill[g] || hit_ret) begin
        v_q <= 1'b0;
      end else if (hit_alloc) begin
        v_q <= 1'b1;
        w_q <= alloc_wrap;
        d_q <= 1'b0;
        f_q <= 1'b0;
        c_q <= '0;
        p_q <= alloc_pc;
      end else if (hit_wb) begin
        d_q <= 1'b1;
        f_q <= wb_fault;
        c_q <= wb_cause;
      end
    end

    assign valid_o[g] = v_q;
    assign wrap_o[g]  = w_q;
    assign done_v[g]  = d_q;
    assign fault_v[g] = f_q;
    assign cause_a[g] = c_q;
    assign pc_a[g]    = p_q;
  end

  assign rd_done  = done_v[rd_idx];
  assign rd_fault = fault_v[rd_idx];
  assign rd_cause = cause_a[rd_idx];
  assign rd_pc    = pc_a[rd_idx];
endmodule

// File: rtl/rob_precise.sv
module rob_precise
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH   = ROB_DEPTH_DEF,
  parameter int unsigned CAUSE_W = ROB_CAUSE_W_DEF,
  parameter int unsigned PC_W    = ROB_PC_W_DEF
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_valid,
  output logic                   disp_ready,
  input  logic [PC_W-1:0]        disp_pc,
  output logic [$clog2(DEPTH):0] disp_tag,
  input  logic                   wb_valid,
  input  logic [$clog2(DEPTH):0] wb_tag,
  input  logic                   wb_fault,
  input  logic [CAUSE_W-1:0]     wb_cause,
  input  logic                   wb_mispredict,
  output logic                   ret_valid,
  input  logic                   ret_ready,
  output logic [$clog2(DEPTH):0] ret_tag,
  output logic [PC_W-1:0]        ret_pc,
  output logic                   ret_exc,
  output logic [CAUSE_W-1:0]     ret_cause,
  output logic                   flush_valid,
  output logic                   flush_all,
  output logic [$clog2(DEPTH):0] flush_tag
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned TAG_W = IDX_W + 1;

  logic [TAG_W-1:0]   head_tag, tail_tag;
  logic               full, empty;
  logic [DEPTH-1:0]   valid_v, wrap_v, kill;
  logic               rd_done, rd_fault;
  logic [CAUSE_W-1:0] rd_cause;
  logic [PC_W-1:0]    rd_pc;
  logic [IDX_W-1:0]   head_idx, wb_idx;
  logic               wb_live, cut, ret_fire, exc_take, disp_fire;
  ptr_cmd_e           cmd;

  assign head_idx = head_tag[IDX_W-1:0];
  assign wb_idx   = wb_tag[IDX_W-1:0];

  // A completion counts only if it names a slot that is held and in the same lap.
  assign wb_live   = wb_valid && valid_v[wb_idx] && (wrap_v[wb_idx] == wb_tag[IDX_W]);

  assign ret_valid = !empty && valid_v[head_idx] && rd_done;
  assign ret_fire  = ret_valid && ret_ready;
  assign exc_take  = ret_fire && rd_fault;
  assign cut       = wb_live && wb_mispredict && !exc_take;

  assign disp_ready = !full && !cut && !exc_take;
  assign disp_fire  = disp_valid && disp_ready;
  assign disp_tag   = tail_tag;

  assign cmd = exc_take ? PTR_CLEAR_ALL : (cut ? PTR_BRANCH_CUT : PTR_HOLD);

  rob_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (disp_fire),
    .retire_fire (ret_fire),
    .cmd         (cmd),
    .cut_tag     (wb_tag),
    .head_tag    (head_tag),
    .tail_tag    (tail_tag),
    .full        (full),
    .empty       (empty)
  );

  rob_squash_mask #(.DEPTH(DEPTH)) u_squash (
    .head_idx  (head_idx),
    .br_idx    (wb_idx),
    .cut_en    (cut),
    .clear_all (exc_take),
    .kill      (kill)
  );

  rob_entry_bank #(.DEPTH(DEPTH), .CAUSE_W(CAUSE_W), .PC_W(PC_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (disp_fire),
    .alloc_idx  (tail_tag[IDX_W-1:0]),
    .alloc_wrap (tail_tag[IDX_W]),
    .alloc_pc   (disp_pc),
    .wb_en      (wb_live),
    .wb_idx     (wb_idx),
    .wb_fault   (wb_fault),
    .wb_cause   (wb_cause),
    .retire_en  (ret_fire && !exc_take),
    .retire_idx (head_idx),
    .kill       (kill),
    .rd_idx     (head_idx),
    .valid_o    (valid_v),
    .wrap_o     (wrap_v),
    .rd_done    (rd_done),
    .rd_fault   (rd_fault),
    .rd_cause   (rd_cause),
    .rd_pc      (rd_pc)
  );

  assign ret_tag     = head_tag;
  assign ret_pc      = rd_pc;
  assign ret_exc     = rd_fault;
  assign ret_cause   = rd_cause;
  assign flush_valid = exc_take || cut;
  assign flush_all   = exc_take;
  assign flush_tag   = exc_take ? head_tag : wb_tag;
endmodule

// File: rtl/rob_precise_chk.sv
module rob_precise_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PC_W  = 32,
  localparam int unsigned TAG_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             full,
  input logic             disp_ready,
  input logic [TAG_W-1:0] disp_tag,
  input logic             ret_valid,
  input logic             ret_ready,
  input logic [TAG_W-1:0] ret_tag,
  input logic [PC_W-1:0]  ret_pc,
  input logic             ret_exc,
  input logic             flush_valid,
  input logic             flush_all,
  input logic [TAG_W-1:0] flush_tag
);
  localparam logic [TAG_W-1:0] ONE = TAG_W'(1);

  // Tag the next retire beat must carry, tracked from the retire stream alone.
  logic [TAG_W-1:0] exp_ret;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      exp_ret <= '0;
    else if (ret_valid && ret_ready) exp_ret <= ret_exc ? '0 : ret_tag + ONE;
  end

  p_full_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !disp_ready);

  p_flush_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !disp_ready);

  p_in_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (ret_tag == exp_ret));

  p_beat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_ready) |=> (ret_valid && ret_tag == $past(ret_tag) && ret_pc == $past(ret_pc)));

  p_flush_only_on_exc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> (ret_valid && ret_ready && ret_exc));

  p_exc_flushes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_ready && ret_exc) |-> (flush_valid && flush_all));

  p_exc_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (!ret_valid && disp_tag == '0));

  p_cut_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && !flush_all) |=> (disp_tag == $past(flush_tag) + ONE));
endmodule

bind rob_precise rob_precise_chk #(.DEPTH(DEPTH), .PC_W(PC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .full        (full),
  .disp_ready  (disp_ready),
  .disp_tag    (disp_tag),
  .ret_valid   (ret_valid),
  .ret_ready   (ret_ready),
  .ret_tag     (ret_tag),
  .ret_pc      (ret_pc),
  .ret_exc     (ret_exc),
  .flush_valid (flush_valid),
  .flush_all   (flush_all),
  .flush_tag   (flush_tag)
);

// File: tb/rob_precise_tb.sv
module rob_precise_tb;
  localparam int unsigned DEPTH   = 8;
  localparam int unsigned CAUSE_W = 4;
  localparam int unsigned PC_W    = 32;
  localparam int unsigned TAG_W   = $clog2(DEPTH) + 1;
  localparam int unsigned NTAG    = 2 ** TAG_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst_n;
  logic               disp_valid, disp_ready;
  logic [PC_W-1:0]    disp_pc;
  logic [TAG_W-1:0]   disp_tag;
  logic               wb_valid, wb_fault, wb_mispredict;
  logic [TAG_W-1:0]   wb_tag;
  logic [CAUSE_W-1:0] wb_cause;
  logic               ret_valid, ret_ready, ret_exc;
  logic [TAG_W-1:0]   ret_tag;
  logic [PC_W-1:0]    ret_pc;
  logic [CAUSE_W-1:0] ret_cause;
  logic               flush_valid, flush_all;
  logic [TAG_W-1:0]   flush_tag;

  rob_precise #(.DEPTH(DEPTH), .CAUSE_W(CAUSE_W), .PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_pc(disp_pc), .disp_tag(disp_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_fault(wb_fault), .wb_cause(wb_cause),
    .wb_mispredict(wb_mispredict),
    .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_tag(ret_tag), .ret_pc(ret_pc),
    .ret_exc(ret_exc), .ret_cause(ret_cause),
    .flush_valid(flush_valid), .flush_all(flush_all), .flush_tag(flush_tag)
  );

  typedef struct {
    logic [TAG_W-1:0] tag;
    logic [PC_W-1:0]  pc;
  } item_t;

  item_t              exp_q[$];
  item_t              mon_it;
  logic               m_fault [NTAG];
  logic [CAUSE_W-1:0] m_cause [NTAG];
  logic [TAG_W-1:0]   m_next;
  logic [TAG_W-1:0]   tg [8];
  int n_run = 0, n_fail = 0, n_retired = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    disp_valid = 1'b0; wb_valid = 1'b0; wb_fault = 1'b0;
    wb_mispredict = 1'b0; wb_cause = '0;
  endtask

  task automatic step();
    @(negedge clk); idle_inputs(); #1;
  endtask

  task automatic dispatch(input logic [PC_W-1:0] pc, output logic [TAG_W-1:0] tag);
    @(negedge clk); idle_inputs();
    disp_valid = 1'b1; disp_pc = pc; #1;
    while (!disp_ready) begin @(negedge clk); #1; end
    check(disp_tag == m_next, "R1", "dispatch tag", disp_tag, m_next);
    tag = m_next;
    exp_q.push_back('{m_next, pc});
    m_fault[m_next] = 1'b0; m_cause[m_next] = '0;
    m_next = m_next + TAG_W'(1);
  endtask

  task automatic complete(input logic [TAG_W-1:0] tag, input logic flt,
                          input logic [CAUSE_W-1:0] cause, input logic mis);
    bit live = 1'b0;
    @(negedge clk); idle_inputs();
    wb_valid = 1'b1; wb_tag = tag; wb_fault = flt; wb_cause = cause; wb_mispredict = mis; #1;
    foreach (exp_q[i]) if (exp_q[i].tag == tag) live = 1'b1;
    if (live) begin
      m_fault[tag] = flt; m_cause[tag] = cause;
      if (mis) begin
        check(flush_valid && !flush_all, "R6", "mispredict flush kind", {flush_valid, flush_all}, 2'b10);
        check(flush_tag == tag, "R6", "flush tag", flush_tag, tag);
        check(!disp_ready, "R2", "ready during flush", disp_ready, 0);
        while (exp_q.size() != 0 && exp_q[$].tag != tag) void'(exp_q.pop_back());
        m_next = tag + TAG_W'(1);
      end else if (flt) begin
        check(!flush_valid, "R4", "no flush on fault report", flush_valid, 0);
      end
    end else begin
      check(!flush_valid, "R7", "stale completion flush", flush_valid, 0);
    end
  endtask

  task automatic drain(input string req);
    int k = 0;
    while (exp_q.size() != 0 && k < 60) begin step(); k++; end
    check(exp_q.size() == 0, req, "drain", exp_q.size(), 0);
    step();
  endtask

  // Monitor: pops the scoreboard on every consumed retire beat.
  always begin
    @(negedge clk); #2;
    if (rst_n && ret_valid && ret_ready) begin
      n_retired++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "retire of discarded instruction", ret_tag, 0);
      end else begin
        mon_it = exp_q.pop_front();
        check(ret_tag == mon_it.tag, "R3", "retire tag", ret_tag, mon_it.tag);
        check(ret_pc == mon_it.pc, "R3", "retire pc", ret_pc, mon_it.pc);
        check(ret_exc == m_fault[mon_it.tag], "R4", "retire exc flag", ret_exc, m_fault[mon_it.tag]);
        if (m_fault[mon_it.tag]) begin
          check(ret_cause == m_cause[mon_it.tag], "R4", "cause", ret_cause, m_cause[mon_it.tag]);
          check(flush_valid && flush_all, "R5", "exception flush", {flush_valid, flush_all}, 2'b11);
          exp_q.delete();
          m_next = '0;
        end else begin
          check(!flush_all, "R5", "no full flush on clean retire", flush_all, 0);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1'b0; ret_ready = 1'b1; disp_pc = '0; wb_tag = '0; m_next = '0;
    idle_inputs();
    for (int i = 0; i < NTAG; i++) begin m_fault[i] = 1'b0; m_cause[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    check(disp_ready == 1'b1, "R8", "reset ready", disp_ready, 1);
    check(ret_valid == 1'b0, "R8", "reset ret_valid", ret_valid, 0);
    check(flush_valid == 1'b0, "R8", "reset flush", flush_valid, 0);
    check(disp_tag == '0, "R8", "reset tag", disp_tag, 0);

    // R3: out-of-order completion, in-order retire
    for (int i = 0; i < 4; i++) dispatch(32'h100 + 4 * i, tg[i]);
    complete(tg[3], 0, 0, 0); complete(tg[1], 0, 0, 0);
    step();
    check(!ret_valid, "R3", "no beat before head completes", ret_valid, 0);
    complete(tg[0], 0, 0, 0); complete(tg[2], 0, 0, 0);
    drain("R3");

    // R2 full stall, R3 back-pressure hold
    ret_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) dispatch(32'h200 + 4 * i, tg[i]);
    step();
    check(!disp_ready, "R2", "ready when full", disp_ready, 0);
    for (int i = DEPTH - 1; i >= 0; i--) complete(tg[i], 0, 0, 0);
    step();
    check(ret_valid && ret_tag == tg[0], "R3", "held beat tag", ret_tag, tg[0]);
    step(); step();
    check(ret_valid && ret_tag == tg[0] && ret_pc == 32'h200, "R3", "beat stable under back-pressure", ret_pc, 32'h200);
    ret_ready = 1'b1;
    drain("R3");

    // R4/R5: fault behind the head waits, then flushes all
    dispatch(32'h300, tg[0]); dispatch(32'h304, tg[1]); dispatch(32'h308, tg[2]);
    complete(tg[1], 1, 4'd5, 0);
    step(); step();
    check(!ret_valid && !flush_valid, "R4", "fault held back", {ret_valid, flush_valid}, 0);
    complete(tg[2], 0, 0, 0); complete(tg[0], 0, 0, 0);
    base = n_retired;
    drain("R5");
    check(n_retired - base == 2, "R5", "younger after fault not retired", n_retired - base, 2);
    check(disp_tag == '0 && !ret_valid, "R5", "empty after exception", disp_tag, 0);

    // R6/R7/R9: fault behind a mispredicted branch vanishes
    dispatch(32'h400, tg[0]); dispatch(32'h404, tg[1]); dispatch(32'h408, tg[2]);
    complete(tg[1], 1, 4'd9, 0);
    base = n_retired;
    complete(tg[0], 0, 0, 1);
    step();
    check(disp_tag == tg[0] + TAG_W'(1), "R6", "tail after cut", disp_tag, tg[0] + TAG_W'(1));
    complete(tg[2], 0, 0, 0);
    drain("R9");
    step(); step();
    check(n_retired - base == 1, "R9", "only branch retired", n_retired - base, 1);
    check(!ret_valid && !flush_valid, "R7", "squashed fault silent", {ret_valid, flush_valid}, 0);

    // R4/R5 with the fault ahead of a mispredicted branch
    dispatch(32'h500, tg[0]); dispatch(32'h504, tg[1]); dispatch(32'h508, tg[2]);
    complete(tg[2], 0, 0, 0);
    complete(tg[1], 0, 0, 1);
    base = n_retired;
    complete(tg[0], 1, 4'd3, 0);
    drain("R4");
    check(n_retired - base == 1, "R5", "branch behind fault discarded", n_retired - base, 1);

    // R1/R3: many laps so tags wrap
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 4; i++) dispatch(32'h1000 + 16 * r + 4 * i, tg[i]);
      complete(tg[2], 0, 0, 0); complete(tg[0], 0, 0, 0);
      complete(tg[3], 0, 0, 0); complete(tg[1], 0, 0, 0);
      drain("R1");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule